// File: doc/BRIEF.md
# Per-Phase Power and Voltage Calibration Pipeline

This block corrects raw per-phase measurement results before they are used further downstream. Each sample arrives with a valid strobe, a phase index and a quantity code that selects active power, reactive power or voltage. The block first scales the value by a gain factor taken from a signed 8-bit coefficient for that phase and quantity. The adjustment span is about ±20% for the two power quantities and about ±8% for voltage.

For the two power quantities, a second stage then adds a small offset correction. This term is a signed 8-bit coefficient for that phase times a fixed constant times a full-scale reference. It takes the sign of the gain-corrected value, which compensates sensor non-linearity at low load. The result is rounded, clamped to the output width and presented two cycles after the input with a valid flag. The pipeline accepts one sample every cycle and never stalls. Coefficients and full-scale references are plain input vectors that are sampled together with the sample.

Top module: `ecal_trim`

## Requirements
- R1: While reset is asserted and after its release until a sample has passed through, `out_valid` is 0 and `out_value` is 0.
- R2: `out_valid` equals `in_valid` from exactly two rising clock edges earlier, for every pattern including back-to-back samples. There are no stalls.
- R3: For quantity codes 0 (active) and 1 (reactive), the gain factor is 1 + c·102/2^16. Here c is the signed byte at bits [(phase·3 + code)·8 +: 8] of `gain_coef`.
- R4: Quantity codes 2 and 3 both mean voltage. The gain factor is 1 + c·41/2^16, with c the byte at bits [(phase·3 + 2)·8 +: 8]. No offset is added, so a nonzero voltage keeps its sign.
- R5: The gain product x·factor is rounded to the nearest integer with ties toward +∞, that is floor((x·factor·2^16 + 2^15)/2^16) in Q16 terms.
- R6: For power, the offset term is floor((o·K·FS + 2^22)/2^23). Here o is the signed byte at bits [(phase·2 + code)·8 +: 8] of `offs_coef`. K is 272 for active power and 299 for reactive power. FS is `fs_act` or `fs_react` respectively.
- R7: The offset term is added when the gain-corrected value is zero or positive, and subtracted when it is negative.
- R8: The final sum saturates to the signed range of `out_value`, from -2^(OUT_W-1) to 2^(OUT_W-1)-1.
- R9: A phase index of PHASES or more selects zero coefficients, so the output equals the input value.
- R10: While `out_valid` is 0, `out_value` holds the last calibrated result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample strobe |
| in_phase | input | PH_W | Phase index of the sample |
| in_kind | input | 2 | Quantity: 0 active, 1 reactive, 2 or 3 voltage |
| in_value | input | DATA_W | Raw signed measurement |
| gain_coef | input | PHASES·3·COEF_W | Signed gain coefficients, per phase and quantity |
| offs_coef | input | PHASES·2·COEF_W | Signed offset coefficients, per phase and power quantity |
| fs_act | input | DATA_W | Unsigned full-scale active power |
| fs_react | input | DATA_W | Unsigned full-scale reactive power |
| out_valid | output | 1 | Result strobe |
| out_value | output | OUT_W | Calibrated signed result |

## Verification
The bench drives the largest positive and most negative inputs at the top gain coefficient, so that a design without clamping would wrap to the opposite sign. It sends a zero-valued power sample with a positive offset and a negative sample with a positive offset. A design that read the sign wrongly, or treated zero as negative, would then move the result the wrong way. It also uses the unpopulated phase index and the spare voltage code, where a wrong coefficient select would show up as a stray gain or offset. Coefficients change while samples are in flight. A design that samples coefficients at different stages from the data would then produce mismatches against the model.

// File: rtl/ecal_pkg.sv
package ecal_pkg;

   typedef enum logic [1:0] {
      QTY_ACT   = 2'd0,
      QTY_REACT = 2'd1,
      QTY_VOLT  = 2'd2,
      QTY_VOLT2 = 2'd3
   } qty_e;

   // fixed-point fraction width of every calibration constant
   localparam int FRAC_W = 16;
   localparam int STEP_W = 8;
   localparam int KOFS_W = 11;

   // gain step per coefficient count, in units of 2^-16
   localparam logic signed [STEP_W-1:0] STEP_PWR  = 8'sd102;
   localparam logic signed [STEP_W-1:0] STEP_VOLT = 8'sd41;

   // offset constants in units of 2^-16
   localparam logic signed [KOFS_W-1:0] KOFS_ACT   = 11'sd272;
   localparam logic signed [KOFS_W-1:0] KOFS_REACT = 11'sd299;

   // coefficient /128 and Q16 constant combined
   localparam int OFS_SHIFT = FRAC_W + 7;

   function automatic logic qty_is_volt(input logic [1:0] q);
      return q[1];
   endfunction

endpackage

// File: rtl/ecal_gain_stage.sv
module ecal_gain_stage
   import ecal_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int COEF_W = 8,
   parameter int PHASES = 3,
   parameter int PH_W   = 2,
   localparam int G_W   = DATA_W + 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic [PH_W-1:0]              in_phase,
   input  logic [1:0]                   in_kind,
   input  logic signed [DATA_W-1:0]     in_value,
   input  logic [PHASES*3*COEF_W-1:0]   gain_coef,
   input  logic [PHASES*2*COEF_W-1:0]   offs_coef,
   input  logic [DATA_W-1:0]            fs_act,
   input  logic [DATA_W-1:0]            fs_react,
   output logic                         s1_valid,
   output logic [1:0]                   s1_kind,
   output logic signed [G_W-1:0]        s1_gain,
   output logic signed [COEF_W-1:0]     s1_ocoef,
   output logic [DATA_W-1:0]            s1_fs
);

   localparam int F_W = FRAC_W + 2;
   localparam int P_W = DATA_W + F_W;
   localparam logic signed [F_W-1:0] UNITY = F_W'(1 << FRAC_W);
   localparam logic signed [P_W-1:0] HALF  = P_W'(1 << (FRAC_W - 1));

   logic signed [COEF_W-1:0] gc;
   logic signed [COEF_W-1:0] oc;
   logic signed [STEP_W-1:0] step;
   logic [1:0]               gidx;
   logic [DATA_W-1:0]        fs_sel;
   logic signed [F_W-1:0]    factor;
   logic signed [P_W-1:0]    prod;
   logic signed [P_W-1:0]    shr;

   always_comb begin
      gidx   = qty_is_volt(in_kind) ? 2'd2 : {1'b0, in_kind[0]};
      step   = qty_is_volt(in_kind) ? STEP_VOLT : STEP_PWR;
      fs_sel = in_kind[0] ? fs_react : fs_act;
      gc     = '0;
      oc     = '0;
      for (int p = 0; p < PHASES; p++) begin
         if (in_phase == PH_W'(p)) begin
            gc = gain_coef[(p*3 + int'(gidx))*COEF_W +: COEF_W];
            if (!qty_is_volt(in_kind))
               oc = offs_coef[(p*2 + int'(in_kind[0]))*COEF_W +: COEF_W];
         end
      end
      factor = UNITY + F_W'(gc) * F_W'(step);
      prod   = P_W'(in_value) * P_W'(factor);
      shr    = (prod + HALF) >>> FRAC_W;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_kind  <= '0;
         s1_gain  <= '0;
         s1_ocoef <= '0;
         s1_fs    <= '0;
      end else begin
         s1_valid <= in_valid;
         if (in_valid) begin
            s1_kind  <= in_kind;
            s1_gain  <= G_W'(shr);
            s1_ocoef <= oc;
            s1_fs    <= fs_sel;
         end
      end
   end

endmodule

// File: rtl/ecal_offset_stage.sv
module ecal_offset_stage
   import ecal_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int COEF_W = 8,
   parameter int OUT_W  = 24,
   localparam int G_W   = DATA_W + 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      s1_valid,
   input  logic [1:0]                s1_kind,
   input  logic signed [G_W-1:0]     s1_gain,
   input  logic signed [COEF_W-1:0]  s1_ocoef,
   input  logic [DATA_W-1:0]         s1_fs,
   output logic                      out_valid,
   output logic signed [OUT_W-1:0]   out_value
);

   localparam int T_W  = COEF_W + KOFS_W + DATA_W + 1;
   localparam int TR_W = T_W - OFS_SHIFT;
   localparam int S_W  = G_W + 1;
   localparam logic signed [T_W-1:0] T_HALF = T_W'(1 << (OFS_SHIFT - 1));

   logic signed [KOFS_W-1:0] kc;
   logic signed [T_W-1:0]    term_raw;
   logic signed [T_W-1:0]    term_shr;
   logic signed [TR_W-1:0]   term;
   logic signed [S_W-1:0]    sum;
   logic signed [OUT_W-1:0]  clamped;

   always_comb begin
      kc       = s1_kind[0] ? KOFS_REACT : KOFS_ACT;
      term_raw = T_W'(s1_ocoef) * T_W'(kc) * T_W'($signed({1'b0, s1_fs}));
      term_shr = (term_raw + T_HALF) >>> OFS_SHIFT;
      term     = TR_W'(term_shr);
      if (qty_is_volt(s1_kind))
         sum = S_W'(s1_gain);
      else if (s1_gain[G_W-1])
         sum = S_W'(s1_gain) - S_W'(term);
      else
         sum = S_W'(s1_gain) + S_W'(term);
   end

   generate
      if (OUT_W >= S_W) begin : g_wide
         assign clamped = OUT_W'(sum);
      end else begin : g_clamp
         localparam logic signed [S_W-1:0] HI = S_W'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
         localparam logic signed [S_W-1:0] LO = S_W'(-(64'sd1 <<< (OUT_W - 1)));
         always_comb begin
            if (sum > HI)
               clamped = OUT_W'(HI);
            else if (sum < LO)
               clamped = OUT_W'(LO);
            else
               clamped = OUT_W'(sum);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_value <= '0;
      end else begin
         out_valid <= s1_valid;
         if (s1_valid)
            out_value <= clamped;
      end
   end

endmodule

// File: rtl/ecal_trim.sv
module ecal_trim
   import ecal_pkg::*;
#(
   parameter int DATA_W = 24,
   parameter int COEF_W = 8,
   parameter int OUT_W  = 24,
   parameter int PHASES = 3,
   parameter int PH_W   = (PHASES > 1) ? $clog2(PHASES) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [PH_W-1:0]             in_phase,
   input  logic [1:0]                  in_kind,
   input  logic signed [DATA_W-1:0]    in_value,
   input  logic [PHASES*3*COEF_W-1:0]  gain_coef,
   input  logic [PHASES*2*COEF_W-1:0]  offs_coef,
   input  logic [DATA_W-1:0]           fs_act,
   input  logic [DATA_W-1:0]           fs_react,
   output logic                        out_valid,
   output logic signed [OUT_W-1:0]     out_value
);

   localparam int G_W = DATA_W + 2;

   generate
      if (COEF_W < 2 || COEF_W > 8) begin : g_bad_coef
         $error("ecal_trim: COEF_W must lie in 2..8");
      end
      if (DATA_W < 8 || DATA_W > 31) begin : g_bad_data
         $error("ecal_trim: DATA_W must lie in 8..31");
      end
      if (OUT_W < DATA_W || OUT_W > 32) begin : g_bad_out
         $error("ecal_trim: OUT_W must lie in DATA_W..32");
      end
      if (PHASES < 1 || (1 << PH_W) < PHASES) begin : g_bad_ph
         $error("ecal_trim: PH_W too narrow for PHASES");
      end
   endgenerate

   logic                     s1_valid;
   logic [1:0]               s1_kind;
   logic signed [G_W-1:0]    s1_gain;
   logic signed [COEF_W-1:0] s1_ocoef;
   logic [DATA_W-1:0]        s1_fs;

   ecal_gain_stage #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .PHASES (PHASES),
      .PH_W   (PH_W)
   ) u_gain (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_phase  (in_phase),
      .in_kind   (in_kind),
      .in_value  (in_value),
      .gain_coef (gain_coef),
      .offs_coef (offs_coef),
      .fs_act    (fs_act),
      .fs_react  (fs_react),
      .s1_valid  (s1_valid),
      .s1_kind   (s1_kind),
      .s1_gain   (s1_gain),
      .s1_ocoef  (s1_ocoef),
      .s1_fs     (s1_fs)
   );

   ecal_offset_stage #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .OUT_W  (OUT_W)
   ) u_ofs (
      .clk       (clk),
      .rst_n     (rst_n),
      .s1_valid  (s1_valid),
      .s1_kind   (s1_kind),
      .s1_gain   (s1_gain),
      .s1_ocoef  (s1_ocoef),
      .s1_fs     (s1_fs),
      .out_valid (out_valid),
      .out_value (out_value)
   );

endmodule

// File: rtl/ecal_trim_chk.sv
module ecal_trim_chk #(
   parameter int DATA_W = 24,
   parameter int OUT_W  = 24,
   parameter int PHASES = 3,
   parameter int PH_W   = 2
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      in_valid,
   input logic [PH_W-1:0]           in_phase,
   input logic [1:0]                in_kind,
   input logic signed [DATA_W-1:0]  in_value,
   input logic                      out_valid,
   input logic signed [OUT_W-1:0]   out_value
);

   // edges seen since reset release, saturating at 2
   logic [1:0] settle;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         settle <= 2'd0;
      else if (settle != 2'd2)
         settle <= settle + 2'd1;
   end

   AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      (settle == 2'd2) |-> (out_valid == $past(in_valid, 2))); // R2

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (settle != 2'd0 && !out_valid) |-> $stable(out_value)); // R10

   AST_PHASE_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (settle == 2'd2 && out_valid && (int'($past(in_phase, 2)) >= PHASES))
      |-> (out_value == $past(in_value, 2))); // R9

   AST_VOLT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (settle == 2'd2 && out_valid && $past(in_kind[1], 2) && ($past(in_value, 2) != 0))
      |-> (out_value[OUT_W-1] == $past(in_value[DATA_W-1], 2))); // R4

   AST_VOLT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (settle == 2'd2 && out_valid && $past(in_kind[1], 2) && ($past(in_value, 2) == 0))
      |-> (out_value == 0)); // R4

endmodule

bind ecal_trim ecal_trim_chk #(
   .DATA_W (DATA_W),
   .OUT_W  (OUT_W),
   .PHASES (PHASES),
   .PH_W   (PH_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_phase  (in_phase),
   .in_kind   (in_kind),
   .in_value  (in_value),
   .out_valid (out_valid),
   .out_value (out_value)
);

// File: tb/test_ecal_trim.sv
module test_ecal_trim;

   localparam int DATA_W = 24;
   localparam int COEF_W = 8;
   localparam int OUT_W  = 24;
   localparam int PHASES = 3;
   localparam int PH_W   = 2;
   localparam longint OMAX = (64'sd1 <<< (OUT_W - 1)) - 1;
   localparam longint OMIN = -(64'sd1 <<< (OUT_W - 1));

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                        rst_n;
   logic                        in_valid;
   logic [PH_W-1:0]             in_phase;
   logic [1:0]                  in_kind;
   logic signed [DATA_W-1:0]    in_value;
   logic [PHASES*3*COEF_W-1:0]  gain_coef;
   logic [PHASES*2*COEF_W-1:0]  offs_coef;
   logic [DATA_W-1:0]           fs_act;
   logic [DATA_W-1:0]           fs_react;
   logic                        out_valid;
   logic signed [OUT_W-1:0]     out_value;

   ecal_trim #(
      .DATA_W (DATA_W),
      .COEF_W (COEF_W),
      .OUT_W  (OUT_W),
      .PHASES (PHASES),
      .PH_W   (PH_W)
   ) i_ecal_trim (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_phase  (in_phase),
      .in_kind   (in_kind),
      .in_value  (in_value),
      .gain_coef (gain_coef),
      .offs_coef (offs_coef),
      .fs_act    (fs_act),
      .fs_react  (fs_react),
      .out_valid (out_valid),
      .out_value (out_value)
   );

   typedef struct {
      bit     v;
      longint d;
      string  tag;
   } exp_t;

   exp_t q[$];
   bit     cur_v;
   longint cur_d;
   string  cur_tag;
   int     total = 0;
   int     bad   = 0;
   bit     done  = 1'b0;

   function automatic longint sbyte(input logic [7:0] b);
      logic signed [7:0] s;
      s = b;
      return longint'(s);
   endfunction

   // behavioural reference built from the requirement text
   function automatic longint model(input int ph, input int kd, input longint x,
                                    output string tag);
      bit     volt;
      longint c, o, g, t, s, fs, step, kc;
      volt = (kd >= 2);
      c = 0;
      o = 0;
      if (ph < PHASES) begin
         c = sbyte(gain_coef[(ph*3 + (volt ? 2 : kd))*8 +: 8]);
         if (!volt) o = sbyte(offs_coef[(ph*2 + kd)*8 +: 8]);
      end
      step = volt ? 41 : 102;
      g = (x * (65536 + c * step) + 32768) >>> 16;
      s = g;
      tag = volt ? "R4 R5" : "R3 R5 R6";
      if (!volt) begin
         kc = (kd == 1) ? 299 : 272;
         fs = (kd == 1) ? longint'(fs_react) : longint'(fs_act);
         t  = (o * kc * fs + (64'sd1 <<< 22)) >>> 23;
         s  = (g < 0) ? g - t : g + t;
         if (t != 0 && g <= 0) tag = {tag, " R7"};
      end
      if (ph >= PHASES) tag = "R9";
      if (s > OMAX) begin s = OMAX; tag = {tag, " R8"}; end
      if (s < OMIN) begin s = OMIN; tag = {tag, " R8"}; end
      return s;
   endfunction

   // reference pipeline: one entry per clock, two edges of delay
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q.delete();
         cur_v   = 1'b0;
         cur_d   = 0;
         cur_tag = "R1";
      end else begin
         exp_t e, f;
         e.v = in_valid;
         e.d = 0;
         e.tag = "";
         if (in_valid) e.d = model(int'(in_phase), int'(in_kind), longint'(in_value), e.tag);
         q.push_back(e);
         if (q.size() > 1) begin
            f = q.pop_front();
            cur_v = f.v;
            if (f.v) begin
               cur_d   = f.d;
               cur_tag = f.tag;
            end else begin
               cur_tag = "R10";
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         total++;
         if (out_valid !== cur_v) begin
            bad++;
            $display("FAIL R2 out_valid actual=%0b expected=%0b", out_valid, cur_v);
         end
         total++;
         if (longint'(out_value) != cur_d) begin
            bad++;
            $display("FAIL %s out_value actual=%0d expected=%0d", cur_tag, out_value, cur_d);
         end
      end
   end

   task automatic send(input int ph, input int kd, input longint x);
      @(negedge clk);
      in_valid = 1'b1;
      in_phase = PH_W'(ph);
      in_kind  = 2'(kd);
      in_value = DATA_W'(x);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
      end
   endtask

   task automatic set_coefs(input bit rnd, input logic [7:0] g, input logic [7:0] o);
      for (int i = 0; i < PHASES*3; i++) gain_coef[i*8 +: 8] = rnd ? 8'($urandom) : g;
      for (int i = 0; i < PHASES*2; i++) offs_coef[i*8 +: 8] = rnd ? 8'($urandom) : o;
   endtask

   initial begin
      #(4 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst_n     = 1'b0;
      in_valid  = 1'b0;
      in_phase  = '0;
      in_kind   = '0;
      in_value  = '0;
      gain_coef = '0;
      offs_coef = '0;
      fs_act    = DATA_W'(24'd8000000);
      fs_react  = DATA_W'(24'd6000000);
      repeat (3) @(negedge clk);
      total++;   // R1 state during reset
      if (out_valid !== 1'b0 || out_value !== '0) begin
         bad++;
         $display("FAIL R1 reset actual=%0b/%0d expected=0/0", out_valid, out_value);
      end
      rst_n = 1'b1;
      idle(3);

      // unity gain, no offset (R3)
      send(0, 0, 1000);
      send(1, 1, -1000);
      send(2, 2, 4000000);
      // top gain at both extremes must clamp (R8)
      set_coefs(0, 8'h7f, 8'h7f);
      send(0, 0, 64'sd8388607);
      send(1, 1, -64'sd8388608);
      send(2, 0, -64'sd8388608);
      // voltage at lowest gain, spare voltage code (R4)
      set_coefs(0, 8'h80, 8'h7f);
      send(0, 2, 100000);
      send(1, 3, -100000);
      send(2, 3, 0);
      // zero value counts as positive, negative value subtracts (R7)
      set_coefs(0, 8'h00, 8'h40);
      send(0, 0, 0);
      send(1, 1, 0);
      send(2, 0, -5000);
      send(0, 1, -1);
      set_coefs(0, 8'h00, 8'hc0);
      send(1, 0, 0);
      send(2, 1, 7);
      // unpopulated phase passes through (R9)
      set_coefs(0, 8'h55, 8'h66);
      send(3, 0, -12345);
      send(3, 2, 777);
      idle(4);
      // output holds while idle (R10), then random traffic
      for (int blk = 0; blk < 60; blk++) begin
         set_coefs(1, 8'h00, 8'h00);
         fs_act   = DATA_W'($urandom);
         fs_react = DATA_W'($urandom);
         for (int i = 0; i < 50; i++) begin
            if ($urandom_range(0, 9) < 7) begin
               longint x;
               case ($urandom_range(0, 5))
                  0: x = 64'sd8388607;
                  1: x = -64'sd8388608;
                  2: x = longint'($urandom_range(0, 200)) - 100;
                  default: x = longint'($signed(DATA_W'($urandom)));
               endcase
               send($urandom_range(0, 3), $urandom_range(0, 3), x);
            end else begin
               idle(1);
            end
         end
      end
      idle(5);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule